// File: doc/BRIEF.md
# Region-Based Memory Protection Unit

This block decides, for every memory access, whether the access may proceed and which memory attributes apply to it. It holds a small set of programmable protection regions. Each region has a base address, a power-of-two size, an enable bit and an attribute set. The attributes are an access-permission code, a cacheable flag, a bufferable flag and an executable flag. Every region has its own comparator, and all comparators are evaluated at the same time. When several enabled regions contain the address, the one with the highest region number is chosen. The chosen region's permission code is then checked against the privilege level and the direction of the access.

Software-side logic programs one whole region per write through a single-cycle write port. Accesses are presented with an address, a supervisor/user flag and a read/write flag. One clock later the block returns the cacheable and bufferable flags, or an abort strobe. A chip uses two copies of the block: one for data and one for instruction fetch. In the fetch copy (parameter `FETCH_CHECK` = 1), the block also aborts when the chosen region is not executable.

Top module: `region_guard`

## Requirements
- R1: After reset every region is disabled and `res_valid`, `res_abort`, `res_cacheable` and `res_bufferable` are 0. The first access after reset therefore aborts.
- R2: Each cycle with `acc_valid` high produces exactly one result, with `res_valid` high in the following cycle. Back-to-back accesses give back-to-back results, and a cycle without an access gives `res_valid` = 0 and `res_abort` = 0.
- R3: A region with size code s covers 2^(12+s) bytes. Codes 20 to 31 cover the whole 4 GB space. Address bits below the region size are ignored in `cfg_base`, so the region is always aligned to its size.
- R4: When several enabled regions contain the address, the region with the highest index determines the result.
- R5: An access whose address lies in no enabled region aborts.
- R6: A region written with `cfg_enable` = 0 does not take part in matching, whatever its base, size and attributes are.
- R7: Permission code 2'b00 aborts every access and 2'b01 allows only supervisor accesses. Code 2'b10 allows supervisor reads and writes but only user reads. Code 2'b11 allows every access.
- R8: A permitted access returns the chosen region's cacheable and bufferable flags. An aborted access returns both flags as 0.
- R9: With `FETCH_CHECK` = 1, an access whose chosen region has `cfg_executable` = 0 aborts. With `FETCH_CHECK` = 0 the executable flag has no effect.
- R10: A write with `cfg_we` high replaces all fields of region `cfg_idx` at that clock edge. It is used by accesses presented from the next cycle on, and it leaves the other regions unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write one region's configuration |
| cfg_idx | input | 3 | Region number to write |
| cfg_base | input | 20 | Region base, address bits 31:12 |
| cfg_size | input | 5 | Size code s, region covers 2^(12+s) bytes |
| cfg_enable | input | 1 | Region takes part in matching |
| cfg_perm | input | 2 | Access-permission code |
| cfg_cacheable | input | 1 | Cacheable attribute |
| cfg_bufferable | input | 1 | Bufferable attribute |
| cfg_executable | input | 1 | Region may be fetched from |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_super | input | 1 | 1 = supervisor, 0 = user |
| acc_write | input | 1 | 1 = write, 0 = read |
| res_valid | output | 1 | Result for the previous cycle's access |
| res_cacheable | output | 1 | Access may be cached |
| res_bufferable | output | 1 | Access may be buffered |
| res_abort | output | 1 | Access is refused |

## Verification
The hardest situation to create from the ports is one in which the priority rule alone decides the outcome. To set it up, a low-numbered region with full access spans the whole space. A mid-sized supervisor-only region sits inside it, and a 4 KB user read-only, non-executable region sits inside that. The bench then walks addresses across every nested edge, with both privilege levels and both directions. Two further cases are built from the same layout. A disabled region with a no-access code is placed over the innermost region, and an unaligned base with a 2 GB size is written to the top region. Regions are then rewritten between back-to-back accesses, so the bench sees both the winner changing and the abort that results when no region is left.

// File: rtl/rg_pkg.sv
`timescale 1ns/1ps
package rg_pkg;

    typedef enum logic [1:0] {
        PERM_NONE    = 2'b00,
        PERM_SUPER   = 2'b01,
        PERM_USER_RO = 2'b10,
        PERM_FULL    = 2'b11
    } perm_e;

    typedef struct packed {
        perm_e perm;
        logic  cacheable;
        logic  bufferable;
        logic  executable;
    } attr_t;

    typedef struct packed {
        logic valid;
        logic cacheable;
        logic bufferable;
        logic abort;
    } result_t;

    // Permission check for one access against one permission code
    function automatic logic perm_allows(perm_e p, logic is_super, logic is_write);
        logic ok;
        case (p)
            PERM_NONE:    ok = 1'b0;
            PERM_SUPER:   ok = is_super;
            PERM_USER_RO: ok = is_super | ~is_write;
            default:      ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/rg_region_bank.sv
`timescale 1ns/1ps
module rg_region_bank
    import rg_pkg::*;
#(
    parameter int N_REGIONS = 8,
    parameter int PN_W      = 20,
    parameter int SIZE_W    = 5,
    localparam int IDX_W    = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic [PN_W-1:0]                     wr_base,
    input  logic [SIZE_W-1:0]                   wr_size,
    input  logic                                wr_enable,
    input  attr_t                               wr_attr,
    output logic [N_REGIONS-1:0][PN_W-1:0]      base_o,
    output logic [N_REGIONS-1:0][SIZE_W-1:0]    size_o,
    output logic [N_REGIONS-1:0]                en_o,
    output attr_t [N_REGIONS-1:0]               attr_o
);

    typedef struct packed {
        logic [N_REGIONS-1:0][PN_W-1:0]   base;
        logic [N_REGIONS-1:0][SIZE_W-1:0] size;
        logic [N_REGIONS-1:0]             en;
        attr_t [N_REGIONS-1:0]            attr;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en && (int'(wr_idx) < N_REGIONS)) begin
            bank_d.base[wr_idx] = wr_base;
            bank_d.size[wr_idx] = wr_size;
            bank_d.en[wr_idx]   = wr_enable;
            bank_d.attr[wr_idx] = wr_attr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign base_o = bank_q.base;
    assign size_o = bank_q.size;
    assign en_o   = bank_q.en;
    assign attr_o = bank_q.attr;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_idx) < N_REGIONS)) |=>
            (en_o[$past(wr_idx)] == $past(wr_enable)) && (size_o[$past(wr_idx)] == $past(wr_size))) // R10
        else $error("region write not stored");

endmodule

// File: rtl/rg_match.sv
`timescale 1ns/1ps
module rg_match #(
    parameter int N_REGIONS = 8,
    parameter int PN_W      = 20,
    parameter int SIZE_W    = 5
) (
    input  logic [PN_W-1:0]                  page,
    input  logic [N_REGIONS-1:0][PN_W-1:0]   base,
    input  logic [N_REGIONS-1:0][SIZE_W-1:0] size,
    input  logic [N_REGIONS-1:0]             en,
    output logic [N_REGIONS-1:0]             hit
);

    // Bits of the page number that take part in the compare for a size code
    function automatic logic [PN_W-1:0] keep_mask(logic [SIZE_W-1:0] s);
        logic [PN_W-1:0] m;
        for (int j = 0; j < PN_W; j++) begin
            m[j] = (j >= int'(s));
        end
        return m;
    endfunction

    for (genvar g = 0; g < N_REGIONS; g++) begin : g_cmp
        logic [PN_W-1:0] mask;
        always_comb begin
            mask   = keep_mask(size[g]);
            hit[g] = en[g] && (((page ^ base[g]) & mask) == '0);
        end
    end

endmodule

// File: rtl/rg_priority.sv
`timescale 1ns/1ps
module rg_priority #(
    parameter int N_REGIONS = 8,
    localparam int IDX_W    = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_REGIONS-1:0] hit,
    output logic                 any_hit,
    output logic [IDX_W-1:0]     win_idx
);

    // Scan upward so the highest-numbered hit is the last assignment
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        for (int i = 0; i < N_REGIONS; i++) begin
            if (hit[i]) begin
                any_hit = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
    end

    AST_WINNER_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> hit[win_idx]) // R4
        else $error("winner is not a hit");

    AST_NONE_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> ((hit >> win_idx) >> 1) == '0) // R4
        else $error("higher region hit but lost");

    AST_MISS_MEANS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |-> (hit == '0)) // R5
        else $error("hit lost by encoder");

endmodule

// File: rtl/region_guard.sv
`timescale 1ns/1ps
module region_guard
    import rg_pkg::*;
#(
    parameter int N_REGIONS   = 8,
    parameter int ADDR_W      = 32,
    parameter int PAGE_BITS   = 12,
    parameter int SIZE_W      = 5,
    parameter bit FETCH_CHECK = 1'b0,
    localparam int PN_W       = ADDR_W - PAGE_BITS,
    localparam int IDX_W      = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [PN_W-1:0]   cfg_base,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              cfg_enable,
    input  logic [1:0]        cfg_perm,
    input  logic              cfg_cacheable,
    input  logic              cfg_bufferable,
    input  logic              cfg_executable,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_super,
    input  logic              acc_write,
    output logic              res_valid,
    output logic              res_cacheable,
    output logic              res_bufferable,
    output logic              res_abort
);

    logic [N_REGIONS-1:0][PN_W-1:0]   reg_base;
    logic [N_REGIONS-1:0][SIZE_W-1:0] reg_size;
    logic [N_REGIONS-1:0]             reg_en;
    attr_t [N_REGIONS-1:0]            reg_attr;
    attr_t                            wr_attr;
    logic [N_REGIONS-1:0]             hit;
    logic                             any_hit;
    logic [IDX_W-1:0]                 win_idx;
    attr_t                            sel_attr;
    logic                             exec_ok;
    logic                             allow;
    logic [PN_W-1:0]                  page;
    logic                             unused_offset;
    result_t                          res_d, res_q;

    assign wr_attr = '{perm: perm_e'(cfg_perm), cacheable: cfg_cacheable,
                       bufferable: cfg_bufferable, executable: cfg_executable};

    rg_region_bank #(.N_REGIONS(N_REGIONS), .PN_W(PN_W), .SIZE_W(SIZE_W)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_idx    (cfg_idx),
        .wr_base   (cfg_base),
        .wr_size   (cfg_size),
        .wr_enable (cfg_enable),
        .wr_attr   (wr_attr),
        .base_o    (reg_base),
        .size_o    (reg_size),
        .en_o      (reg_en),
        .attr_o    (reg_attr)
    );

    assign page          = acc_addr[ADDR_W-1:PAGE_BITS];
    assign unused_offset = ^acc_addr[PAGE_BITS-1:0];

    rg_match #(.N_REGIONS(N_REGIONS), .PN_W(PN_W), .SIZE_W(SIZE_W)) i_match (
        .page (page),
        .base (reg_base),
        .size (reg_size),
        .en   (reg_en),
        .hit  (hit)
    );

    rg_priority #(.N_REGIONS(N_REGIONS)) i_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .any_hit (any_hit),
        .win_idx (win_idx)
    );

    assign sel_attr = reg_attr[win_idx];

    if (FETCH_CHECK) begin : g_fetch
        assign exec_ok = sel_attr.executable;

        AST_NOT_EXEC_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && any_hit && !sel_attr.executable) |=> res_abort) // R9
            else $error("fetch from non-executable region allowed");
    end else begin : g_data
        logic unused_exec;
        assign unused_exec = sel_attr.executable;
        assign exec_ok     = 1'b1;
    end

    assign allow = any_hit && exec_ok && perm_allows(sel_attr.perm, acc_super, acc_write);

    always_comb begin
        res_d            = '0;
        res_d.valid      = acc_valid;
        res_d.abort      = acc_valid && !allow;
        res_d.cacheable  = acc_valid && allow && sel_attr.cacheable;
        res_d.bufferable = acc_valid && allow && sel_attr.bufferable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid      = res_q.valid;
    assign res_cacheable  = res_q.cacheable;
    assign res_bufferable = res_q.bufferable;
    assign res_abort      = res_q.abort;

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid) // R2
        else $error("access without result");

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!res_valid && !res_abort)) // R2
        else $error("result without access");

    AST_MISS_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !any_hit) |=> res_abort) // R5
        else $error("unmatched access allowed");

    AST_ABORT_NO_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
        res_abort |-> (!res_cacheable && !res_bufferable)) // R8
        else $error("attributes on aborted access");

    AST_USER_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && any_hit && !acc_super && acc_write && sel_attr.perm == PERM_USER_RO)
            |=> res_abort) // R7
        else $error("user write to read-only region allowed");

endmodule

// File: tb/test_region_guard.sv
`timescale 1ns/1ps
module test_region_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [19:0] cfg_base = '0;
    logic [4:0]  cfg_size = '0;
    logic        cfg_enable = 1'b0;
    logic [1:0]  cfg_perm = '0;
    logic        cfg_cacheable = 1'b0;
    logic        cfg_bufferable = 1'b0;
    logic        cfg_executable = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_super = 1'b0;
    logic        acc_write = 1'b0;
    logic        d_valid, d_c, d_b, d_abort;
    logic        f_valid, f_c, f_b, f_abort;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    region_guard #(.FETCH_CHECK(1'b0)) i_region_guard (
        .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_base, .cfg_size, .cfg_enable,
        .cfg_perm, .cfg_cacheable, .cfg_bufferable, .cfg_executable,
        .acc_valid, .acc_addr, .acc_super, .acc_write,
        .res_valid(d_valid), .res_cacheable(d_c), .res_bufferable(d_b), .res_abort(d_abort)
    );

    region_guard #(.FETCH_CHECK(1'b1)) i_region_guard_fetch (
        .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_base, .cfg_size, .cfg_enable,
        .cfg_perm, .cfg_cacheable, .cfg_bufferable, .cfg_executable,
        .acc_valid, .acc_addr, .acc_super, .acc_write,
        .res_valid(f_valid), .res_cacheable(f_c), .res_bufferable(f_b), .res_abort(f_abort)
    );

    typedef struct packed {
        logic abort;
        logic c;
        logic b;
        logic fabort;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cfg(input int idx, input logic [19:0] base, input logic [4:0] size,
                       input logic en, input logic [1:0] perm, input logic c, input logic b, input logic x);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_base = base; cfg_size = size;
        cfg_enable = en; cfg_perm = perm; cfg_cacheable = c; cfg_bufferable = b; cfg_executable = x;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Driver: presents one access and queues what both instances must return
    task automatic access(input logic [31:0] a, input logic sup, input logic wr,
                          input logic ab, input logic c, input logic b, input logic fab, input string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_super = sup; acc_write = wr;
        exp_q.push_back('{abort: ab, c: c, b: b, fabort: fab});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            acc_valid = 1'b0;
        end
    endtask

    // Monitor: pops one expected item per result
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2", "fetch valid matches data valid", 32'(f_valid), 32'(d_valid));
            if (d_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R2", "result without access", 32'(1), 32'(0));
                end else begin
                    exp_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(t, "data abort", 32'(d_abort), 32'(e.abort));
                    chk(t, "data cacheable", 32'(d_c), 32'(e.c));
                    chk(t, "data bufferable", 32'(d_b), 32'(e.b));
                    chk(t, "fetch abort", 32'(f_abort), 32'(e.fabort));
                    chk(t, "fetch cacheable", 32'(f_c), 32'(e.fabort ? 1'b0 : e.c));
                    chk(t, "fetch bufferable", 32'(f_b), 32'(e.fabort ? 1'b0 : e.b));
                end
            end else begin
                chk("R2", "no abort while idle", 32'(d_abort), 32'(0));
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", 32'(d_valid), 32'(0));
        chk("R1", "abort in reset", 32'(d_abort), 32'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid after reset", 32'(d_valid), 32'(0));
        chk("R1", "cacheable after reset", 32'(d_c | d_b), 32'(0));

        // R1 R5: nothing enabled, every access aborts
        access(32'h0000_1000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R1 no region after reset");
        idle(2);

        // Background region 0: whole space, full access
        cfg(0, 20'h00000, 5'd20, 1'b1, 2'b11, 1'b0, 1'b0, 1'b1);
        // Region 1: 256 KB at 0x40000, supervisor only
        cfg(1, 20'h00040, 5'd6, 1'b1, 2'b01, 1'b1, 1'b1, 1'b1);
        // Region 3: 4 KB at 0x50000, user read-only, not executable
        cfg(3, 20'h00050, 5'd0, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0);
        // Region 5: disabled, no access, over region 3
        cfg(5, 20'h00050, 5'd0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        // Region 7: 2 GB, unaligned base, no access
        cfg(7, 20'h80123, 5'd19, 1'b1, 2'b00, 1'b1, 1'b1, 1'b1);

        access(32'h0000_1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 whole-space region");
        access(32'h0000_1000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7 full access user write");
        access(32'h0004_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R7 supervisor-only user read");
        access(32'h0004_0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R8 supervisor write attrs");
        access(32'h0007_FFFC, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R3 last word of 256 KB");
        access(32'h0008_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 first byte past region");
        access(32'h0003_FFFC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 last byte below region");
        access(32'h0005_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R4 R6 R9 nested user read");
        access(32'h0005_0FFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R7 user write read-only");
        access(32'h0005_0004, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R7 R9 supervisor write read-only");
        access(32'h0005_1000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R3 R4 past 4 KB region");
        access(32'h8000_0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R3 R4 unaligned base top region");
        access(32'hFFFF_FFFC, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R7 no-access top word");
        access(32'h7FFF_FFFC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 just below 2 GB region");
        idle(2);

        // R10: rewrites take effect for the next access, others kept
        cfg(7, 20'h80000, 5'd19, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1);
        access(32'h8000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 R6 region disabled by write");
        idle(1);
        cfg(0, 20'h00000, 5'd20, 1'b0, 2'b11, 1'b0, 1'b0, 1'b1);
        access(32'h9000_0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R5 no enabled region");
        access(32'h0005_0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R10 other region kept");
        access(32'h0006_0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R10 region 1 kept");
        idle(4);

        chk("R2", "all results delivered", 32'(exp_q.size()), 32'(0));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule